// File: doc/BRIEF.md
# Bus Data Parity Generator and Checker

This block sits beside one agent on a 32-bit synchronous multiplexed address/data bus. It covers parity in both directions. Each rising clock edge it samples the data lines, the active-low byte-enable/command lines and the two active-low ready lines. A data transfer happens only on an edge where both ready lines are low. The block learns its role for the current transaction from two inputs: whether it is the target, and whether the transaction is a write. From these it works out whether it supplies the data or receives it.

When it supplies the data, the block drives the parity bit during the clock that follows each transfer. A fault-injection input inverts that bit, so a wrong-parity read or write can be produced on purpose. When it receives the data, it samples the parity bit one edge after the transfer and compares it with the parity it computed itself. On a mismatch it pulls its active-low parity-error line low, timed so that the line is seen asserted two edges after the faulty transfer. It then drives the line high for one clock before releasing it. A sticky flag records every mismatch, whether or not error reporting is enabled.

Top module: `parity_guard`

## Requirements
- R1: While reset is held, par_oe_o = 0, perr_oe_o = 0, perr_n_o = 1 and par_err_seen_o = 0, and par_o = 0.
- R2: A transfer occurs only on a rising edge where xact_i = 1, irdy_n_i = 0 and trdy_n_i = 0. An edge without a transfer enables no parity output on the next cycle and starts no parity check.
- R3: The block is the data driver when is_target_i differs from is_write_i. For a driver transfer at edge k, par_o equals the XOR of ad_i and cbe_n_i sampled at edge k, so the ones across data, byte enables and parity are even. par_oe_o = 1 between edge k and edge k+1.
- R4: par_oe_o returns to 0 after one cycle unless another driver transfer occurs. par_o keeps its last value through wait states and receive phases.
- R5: With inj_par_err_i = 1 at a driver transfer edge, par_o is the inverse of the correct parity.
- R6: The block is the receiver when is_target_i equals is_write_i. For a receiver transfer at edge k, par_i sampled at edge k+1 is compared with the parity of that transfer. On a mismatch with perr_en_i = 1 at edge k+1, perr_n_o = 0 and perr_oe_o = 1 from edge k+1 to edge k+2.
- R7: A mismatch seen while perr_en_i = 0 leaves perr_n_o = 1 and perr_oe_o = 0.
- R8: par_err_seen_o goes to 1 on the edge where any mismatch is detected and stays at 1 until reset.
- R9: After its last low cycle, perr_n_o is 1 with perr_oe_o = 1 for exactly one cycle. Then perr_oe_o is 0.
- R10: In a driver phase the block checks nothing: par_i never causes an error. In a receiver phase inj_par_err_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| xact_i | input | 1 | This agent takes part in the current transaction |
| is_target_i | input | 1 | 1 = this agent is the target, 0 = the initiator |
| is_write_i | input | 1 | 1 = write transaction, 0 = read |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| ad_i | input | DATA_W | Sampled address/data lines |
| cbe_n_i | input | DATA_W/8 | Sampled command/byte-enable lines, active low |
| par_i | input | 1 | Parity bit sampled from the bus |
| perr_en_i | input | 1 | Allows the parity-error line to be driven |
| inj_par_err_i | input | 1 | Makes the next driven parity bit wrong |
| par_o | output | 1 | Parity bit to drive |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Parity-error line, active low |
| perr_oe_o | output | 1 | Output enable for perr_n_o |
| par_err_seen_o | output | 1 | Sticky flag: a parity mismatch was detected |

## Verification
The bench builds the block with the default DATA_W of 32. This gives four byte-enable lines and a 36-bit parity input split into five 8-bit lanes. The last lane is partly zero-padded, so the padding path of the reduction tree gets exercised. Data patterns with odd and even one-counts, across all lanes and the byte-enable field, bring both parity values within reach. All four role combinations, and wait states from either ready line, cover the transfer and role decoding.

// File: rtl/parity_guard_pkg.sv
package parity_guard_pkg;

  // Width of one reduction lane in the parity tree.
  localparam int LANE_BITS = 8;

  // Sequencer for the parity-error line.
  typedef enum logic [1:0] {
    PERR_IDLE = 2'b00,  // line released
    PERR_LOW  = 2'b01,  // line driven low (error)
    PERR_HIGH = 2'b10   // line driven high before release
  } perr_state_e;

endpackage

// File: rtl/pg_xor_tree.sv
module pg_xor_tree #(
  parameter int W      = 36,
  parameter int LANE_W = 8,
  localparam int LANES = (W + LANE_W - 1) / LANE_W,
  localparam int PAD_W = LANES * LANE_W
) (
  input  logic [W-1:0] vec_i,
  output logic         par_o
);

  logic [PAD_W-1:0] padded;
  logic [LANES-1:0] lane_par;

  always_comb begin
    padded          = '0;
    padded[W-1:0]   = vec_i;
  end

  // One XOR reduction per lane, then a reduction across lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
  end

  assign par_o = ^lane_par;

endmodule

// File: rtl/pg_role_decode.sv
module pg_role_decode (
  input  logic xact_i,
  input  logic is_target_i,
  input  logic is_write_i,
  input  logic irdy_n_i,
  input  logic trdy_n_i,
  output logic drv_xfer_o,
  output logic rcv_xfer_o
);

  logic xfer;
  logic drives;

  always_comb begin
    // Data moves only when both ready lines are low.
    xfer   = xact_i & ~irdy_n_i & ~trdy_n_i;
    // Initiator on a write, or target on a read, supplies the data.
    drives = is_target_i ^ is_write_i;
    drv_xfer_o = xfer &  drives;
    rcv_xfer_o = xfer & ~drives;
  end

endmodule

// File: rtl/pg_par_driver.sv
module pg_par_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic sum_par_i,
  input  logic inj_i,
  output logic par_o,
  output logic par_oe_o
);

  logic par_d, par_q;
  logic oe_d, oe_q;

  always_comb begin
    par_d = sum_par_i ^ inj_i;
    oe_d  = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= oe_d;
      if (load_i) begin
        par_q <= par_d;
      end
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

endmodule

// File: rtl/pg_perr_check.sv
module pg_perr_check
  import parity_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sum_par_i,
  input  logic par_i,
  input  logic en_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic seen_o
);

  logic        pend_q;
  logic        exp_q;
  logic        seen_d, seen_q;
  logic        mism;
  logic        report;
  perr_state_e st_d, st_q;

  always_comb begin
    // Parity bit arrives one edge after the data it covers.
    mism   = pend_q & (par_i != exp_q);
    report = mism & en_i;
    seen_d = seen_q | mism;
    unique case (st_q)
      PERR_IDLE: st_d = report ? PERR_LOW : PERR_IDLE;
      PERR_LOW:  st_d = report ? PERR_LOW : PERR_HIGH;
      PERR_HIGH: st_d = report ? PERR_LOW : PERR_IDLE;
      default:   st_d = PERR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      seen_q <= 1'b0;
      st_q   <= PERR_IDLE;
    end else begin
      pend_q <= arm_i;
      if (arm_i) begin
        exp_q <= sum_par_i;
      end
      seen_q <= seen_d;
      st_q   <= st_d;
    end
  end

  assign perr_n_o  = (st_q != PERR_LOW);
  assign perr_oe_o = (st_q != PERR_IDLE);
  assign seen_o    = seen_q;

endmodule

// File: rtl/parity_guard.sv
module parity_guard
  import parity_guard_pkg::*;
#(
  parameter int  DATA_W = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int SUM_W  = DATA_W + BE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_i,
  input  logic              is_target_i,
  input  logic              is_write_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_n_i,
  input  logic              par_i,
  input  logic              perr_en_i,
  input  logic              inj_par_err_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              par_err_seen_o
);

  logic drv_xfer;
  logic rcv_xfer;
  logic sum_par;

  pg_role_decode u_role (
    .xact_i      (xact_i),
    .is_target_i (is_target_i),
    .is_write_i  (is_write_i),
    .irdy_n_i    (irdy_n_i),
    .trdy_n_i    (trdy_n_i),
    .drv_xfer_o  (drv_xfer),
    .rcv_xfer_o  (rcv_xfer)
  );

  pg_xor_tree #(
    .W      (SUM_W),
    .LANE_W (LANE_BITS)
  ) u_tree (
    .vec_i ({cbe_n_i, ad_i}),
    .par_o (sum_par)
  );

  pg_par_driver u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (drv_xfer),
    .sum_par_i (sum_par),
    .inj_i     (inj_par_err_i),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o)
  );

  pg_perr_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (rcv_xfer),
    .sum_par_i (sum_par),
    .par_i     (par_i),
    .en_i      (perr_en_i),
    .perr_n_o  (perr_n_o),
    .perr_oe_o (perr_oe_o),
    .seen_o    (par_err_seen_o)
  );

endmodule

// File: rtl/parity_guard_sva.sv
module parity_guard_sva #(
  parameter int  DATA_W = 32,
  localparam int BE_W   = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xact_i,
  input logic              is_target_i,
  input logic              is_write_i,
  input logic              irdy_n_i,
  input logic              trdy_n_i,
  input logic [DATA_W-1:0] ad_i,
  input logic [BE_W-1:0]   cbe_n_i,
  input logic              par_i,
  input logic              perr_en_i,
  input logic              inj_par_err_i,
  input logic              par_o,
  input logic              par_oe_o,
  input logic              perr_n_o,
  input logic              perr_oe_o,
  input logic              par_err_seen_o
);

  logic xfer_c, drv_c, bus_par_c;
  assign xfer_c    = xact_i & ~irdy_n_i & ~trdy_n_i;
  assign drv_c     = is_target_i ^ is_write_i;
  assign bus_par_c = ^{cbe_n_i, ad_i};

  // R2: no transfer, no parity enable next cycle
  assert_no_par_without_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_c |=> !par_oe_o);

  // R3 and R5: parity bit follows the driver transfer, inverted on injection
  assert_par_follows_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_c && drv_c) |=> (par_oe_o && (par_o == ($past(bus_par_c) ^ $past(inj_par_err_i)))));

  // R4: parity bit holds without a driver transfer
  assert_par_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_c && drv_c) |=> $stable(par_o));

  // R6: receiver mismatch gives a low error line on the next cycle
  assert_perr_on_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_c && !drv_c) ##1 (perr_en_i && (par_i != $past(bus_par_c))) |=> !perr_n_o);

  // R6: the line is low only while enabled
  assert_low_only_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o);

  // R7: disabled reporting keeps the line high
  assert_perr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_en_i |=> perr_n_o);

  // R8: the flag is sticky
  assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_seen_o |=> par_err_seen_o);

  // R8: the flag accompanies every low pulse
  assert_seen_with_perr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> par_err_seen_o);

  // R9: the release is preceded by a driven-high cycle
  assert_release_after_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_oe_o) |-> $past(perr_n_o));

  // R9: the rise of the line happens while still enabled
  assert_rise_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_n_o) |-> perr_oe_o);

endmodule

bind parity_guard parity_guard_sva #(.DATA_W(DATA_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .xact_i         (xact_i),
  .is_target_i    (is_target_i),
  .is_write_i     (is_write_i),
  .irdy_n_i       (irdy_n_i),
  .trdy_n_i       (trdy_n_i),
  .ad_i           (ad_i),
  .cbe_n_i        (cbe_n_i),
  .par_i          (par_i),
  .perr_en_i      (perr_en_i),
  .inj_par_err_i  (inj_par_err_i),
  .par_o          (par_o),
  .par_oe_o       (par_oe_o),
  .perr_n_o       (perr_n_o),
  .perr_oe_o      (perr_oe_o),
  .par_err_seen_o (par_err_seen_o)
);

// File: tb/parity_guard_tb.sv
module parity_guard_tb;

  localparam int  DATA_W   = 32;
  localparam int  BE_W     = DATA_W / 8;
  localparam time CLK_HALF = 5ns;
  localparam int  MAX_CYC  = 200000;

  logic              clk;
  logic              rst_n;
  logic              xact, tgt, wr, irdy_n, trdy_n, par_in, en, inj;
  logic [DATA_W-1:0] ad;
  logic [BE_W-1:0]   cbe_n;
  logic              par_o, par_oe_o, perr_n_o, perr_oe_o, seen_o;

  parity_guard #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .xact_i(xact), .is_target_i(tgt), .is_write_i(wr),
    .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par_in),
    .perr_en_i(en), .inj_par_err_i(inj), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .par_err_seen_o(seen_o)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  typedef struct {
    logic  par, poe, pn, poe_e, seen;
    string tag;
  } exp_t;

  exp_t  sbq[$];
  exp_t  it;
  int    n_run  = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // Reference model state, built from the requirements.
  logic m_par, m_poe, m_pend, m_exp, m_seen, m_pn, m_pe;
  int   m_st;

  // Monitor: compares outputs at each falling edge against the scoreboard.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      n_run++;
      if ({par_o, par_oe_o, perr_n_o, perr_oe_o, seen_o} !==
          {it.par, it.poe, it.pn, it.poe_e, it.seen}) begin
        n_fail++;
        $display("FAIL %s: par/par_oe/perr_n/perr_oe/seen actual %b%b%b%b%b expected %b%b%b%b%b",
                 it.tag, par_o, par_oe_o, perr_n_o, perr_oe_o, seen_o,
                 it.par, it.poe, it.pn, it.poe_e, it.seen);
      end
    end
  end

  // Driver: applies one edge of stimulus and pushes the predicted outputs.
  task automatic step(input logic x, input logic t, input logic w, input logic ir,
                      input logic tr, input logic [DATA_W-1:0] d, input logic [BE_W-1:0] c,
                      input logic p, input logic ij, input logic e);
    logic xf, dr, mm, sp;
    exp_t ex;
    @(negedge clk);
    #1;
    xact = x; tgt = t; wr = w; irdy_n = ir; trdy_n = tr;
    ad = d; cbe_n = c; par_in = p; inj = ij; en = e;
    @(posedge clk);
    #1;
    xf = x & ~ir & ~tr;
    dr = t ^ w;
    sp = ^{c, d};
    mm = m_pend & (p != m_exp);
    if (mm) m_seen = 1'b1;
    if (mm && e)      begin m_st = 1; end
    else if (m_st == 1) begin m_st = 2; end
    else              begin m_st = 0; end
    m_pn = (m_st != 1);
    m_pe = (m_st != 0);
    m_pend = xf & ~dr;
    if (xf && !dr) m_exp = sp;
    if (xf && dr)  m_par = sp ^ ij;
    m_poe = xf & dr;
    ex.par = m_par; ex.poe = m_poe; ex.pn = m_pn; ex.poe_e = m_pe;
    ex.seen = m_seen; ex.tag = cur_tag;
    sbq.push_back(ex);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  // Watchdog.
  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    xact = 0; tgt = 0; wr = 0; irdy_n = 1; trdy_n = 1; ad = '0; cbe_n = '0;
    par_in = 0; inj = 0; en = 1;
    m_par = 0; m_poe = 0; m_pend = 0; m_exp = 0; m_seen = 0; m_pn = 1; m_pe = 0; m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    n_run++;
    if ({par_o, par_oe_o, perr_n_o, perr_oe_o, seen_o} !== 5'b00100) begin
      n_fail++;
      $display("FAIL R1: actual %b%b%b%b%b expected 00100",
               par_o, par_oe_o, perr_n_o, perr_oe_o, seen_o);
    end
    rst_n = 1'b1;

    // R2: transfers with xact low do nothing
    cur_tag = "R2";
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 4'h0, 1'b1, 1'b0, 1'b1);

    // R3: initiator write, varied patterns
    cur_tag = "R3";
    step(1, 0, 1, 0, 0, 32'h0000_0001, 4'h0, 0, 0, 1);
    step(1, 0, 1, 0, 0, 32'hFFFF_FFFF, 4'hF, 0, 0, 1);
    step(1, 0, 1, 0, 0, 32'hA5A5_5A5A, 4'h3, 0, 0, 1);
    step(1, 0, 1, 0, 0, 32'h0000_0007, 4'h0, 0, 0, 1);
    step(1, 0, 1, 0, 0, 32'h0000_0000, 4'h8, 0, 0, 1);

    // R4: wait states from either ready line hold par_o
    cur_tag = "R4";
    step(1, 0, 1, 1, 0, 32'h0000_0000, 4'h0, 0, 0, 1);
    step(1, 0, 1, 0, 1, 32'h0000_0003, 4'h0, 0, 0, 1);
    step(1, 0, 1, 1, 1, 32'h0000_0000, 4'h0, 0, 0, 1);

    // R5: injection inverts driven parity
    cur_tag = "R5";
    step(1, 0, 1, 0, 0, 32'h0000_0001, 4'h0, 0, 1, 1);
    step(1, 0, 1, 0, 0, 32'h8000_0000, 4'h1, 0, 1, 1);

    // R3: target read also drives
    cur_tag = "R3";
    step(1, 1, 0, 0, 0, 32'h0001_0000, 4'h0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 32'h0001_0001, 4'h0, 0, 0, 1);

    // R10: driver phase ignores a wrong par_i
    cur_tag = "R10";
    step(1, 0, 1, 0, 0, 32'h0000_00FF, 4'h0, 1, 0, 1);
    step(1, 0, 1, 0, 0, 32'h0000_000F, 4'h1, 0, 0, 1);
    step(1, 0, 1, 1, 1, 32'h0, 4'h0, 1, 0, 1);

    // R6: target write with correct parity -> no error
    cur_tag = "R6";
    step(1, 1, 1, 0, 0, 32'h1234_5678, 4'h0, 0, 0, 1);
    step(1, 1, 1, 1, 1, 32'h0, 4'h0, 1, 0, 1);   // 13 ones -> parity 1, correct
    idle(2);

    // R7: mismatch with reporting disabled
    cur_tag = "R7";
    step(1, 1, 1, 0, 0, 32'h0000_0003, 4'h0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 32'h0, 4'h0, 1, 0, 0);   // correct is 0
    step(0, 0, 0, 1, 1, 32'h0, 4'h0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 32'h0, 4'h0, 0, 0, 0);

    // R8: flag stays set
    cur_tag = "R8";
    idle(3);

    // R6 and R9: mismatch with reporting on, then release sequence
    cur_tag = "R6";
    step(1, 1, 1, 0, 0, 32'h0000_0001, 4'h0, 0, 0, 1);
    step(1, 1, 1, 1, 1, 32'h0, 4'h0, 0, 0, 1);   // correct is 1
    cur_tag = "R9";
    idle(4);

    // R6: initiator read receives, mismatch
    cur_tag = "R6";
    step(1, 0, 0, 0, 0, 32'h0000_0000, 4'hE, 1, 0, 1);
    step(1, 0, 0, 1, 1, 32'h0, 4'h0, 0, 0, 1);   // correct is 1
    cur_tag = "R9";
    idle(4);

    // R2: receiver wait states never start a check
    cur_tag = "R2";
    step(1, 1, 1, 1, 0, 32'h0000_0001, 4'h0, 0, 0, 1);
    step(1, 1, 1, 0, 1, 32'h0000_0001, 4'h0, 0, 0, 1);
    step(1, 1, 1, 1, 1, 32'h0, 4'h0, 0, 0, 1);
    idle(2);

    // R10: injection has no effect while receiving
    cur_tag = "R10";
    step(1, 1, 1, 0, 0, 32'h0000_0005, 4'h0, 1, 1, 1);
    step(1, 1, 1, 1, 1, 32'h0, 4'h0, 0, 1, 1);   // correct is 0
    idle(3);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule